// File: doc/BRIEF.md
# Bit-Serial Shift-and-Add Multiplier

This block forms the unsigned product of two N-bit operands using one full adder and a handful of shift registers. The work runs one bit per clock. An outer loop steps through the bits of the multiplier operand. For each of those bits, an inner loop streams the multiplicand through the adder and adds its partial product into the running upper half of the result. Both loop indices are plain binary counters. Each counter has a count enable, a synchronous clear and a terminal-count flag, and a three-state controller drives them.

A caller presents both operands and pulses `start` while the block is idle. After N*(N+1) working cycles the controller returns to idle and raises `done` for one cycle. At that point `{prod_hi, prod_lo}` holds the 2N-bit product. The product stays in place until the next accepted `start`.

The controller has three states: `ST_IDLE`, `ST_INNER` and `ST_OUTER`. There are five transitions:
- idle-to-inner, when `start` is seen in `ST_IDLE`.
- inner-stay, while the inner counter is below its terminal count.
- inner-to-outer, when the inner counter reaches terminal count.
- outer-to-inner, when the outer counter is below its terminal count.
- outer-to-idle, when the outer counter reaches terminal count. This transition also raises `done`.

Top module: `serial_mult`

## Requirements
- R1: While reset is active and in the first cycle after it, `done` is 0, `prod_hi` and `prod_lo` are 0, and the controller is in `ST_IDLE`.
- R2: In `ST_IDLE`, a high `start` does all of the following on one edge: captures `op_a` and `op_b`, clears the product registers and the carry flop, clears both loop counters, and enters `ST_INNER`.
- R3: Each `ST_INNER` cycle does four things:
  - adds bit 0 of the upper product, (A bit 0 AND B bit 0) and the registered carry;
  - rotates A right by one;
  - shifts the sum into the upper product's MSB and stores the carry-out;
  - advances the inner counter.
  At inner count N-1 the next state is `ST_OUTER`.
- R4: Each `ST_OUTER` cycle does five things:
  - shifts B right by one;
  - shifts the upper product right, taking the carry into its MSB;
  - shifts the lower product right, taking the upper product's old bit 0 into its MSB;
  - clears the carry flop and the inner counter;
  - advances the outer counter.
- R5: `done` is high for exactly one cycle. It first appears N*(N+1)+1 rising edges after and including the edge that sampled `start`, and the controller is then in `ST_IDLE`.
- R6: When `done` is high, `{prod_hi, prod_lo}` equals `op_a * op_b` as unsigned numbers, for the operands captured at `start`. This holds at both N=4 and N=8.
- R7: `start` and operand changes have no effect outside `ST_IDLE`. Neither the product nor the latency of a multiply in progress changes.
- R8: In `ST_IDLE` with `start` low, `prod_hi` and `prod_lo` hold their values whatever the operand inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a multiply; honoured only when idle |
| op_a | input | N | Multiplicand |
| op_b | input | N | Multiplier |
| done | output | 1 | One-cycle pulse when the product is complete |
| prod_hi | output | N | Upper half of the product |
| prod_lo | output | N | Lower half of the product |

## Verification
The checker watches the control schedule on every cycle:
- each state transition happens on the right counter value;
- the inner counter steps by one;
- the carry is clear after each outer step;
- `done` is a single pulse that occurs only on the outer-to-idle transition;
- the product registers stay frozen while the block is idle.

Whether the shifted and added bits form the correct product needs whole multiplies checked against a reference. The bench runs these at both widths, using corner operands and seeded random operands. It also injects `start` and operand changes during a multiply to confirm they are ignored.

// File: rtl/serial_mult_pkg.sv
package serial_mult_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_INNER = 2'd1,
        ST_OUTER = 2'd2
    } mul_state_t;
endpackage

// File: rtl/serial_mult_counter.sv
module serial_mult_counter #(
    parameter  int LIMIT = 8,
    localparam int CW    = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          ce,
    output logic [CW-1:0] count,
    output logic          tc
);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    assign tc = (count == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= '0;
        else if (clr)
            count <= '0;
        else if (ce)
            count <= tc ? '0 : count + CW'(1);
    end
endmodule

// File: rtl/serial_mult_ctrl.sv
module serial_mult_ctrl
    import serial_mult_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       tc_in,
    input  logic       tc_out,
    output mul_state_t state,
    output logic       done,
    output logic       load,
    output logic       shift_a,
    output logic       sel_sum,
    output logic       shift_hi,
    output logic       shift_b,
    output logic       shift_lo,
    output logic       clr_carry,
    output logic       clr_in,
    output logic       ce_in,
    output logic       clr_out,
    output logic       ce_out
);
    mul_state_t next;

    // state register and registered done pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            done  <= 1'b0;
        end else begin
            state <= next;
            done  <= (state == ST_OUTER) && tc_out;
        end
    end

    // next state and control strobes
    always_comb begin
        next      = state;
        load      = 1'b0;
        shift_a   = 1'b0;
        sel_sum   = 1'b0;
        shift_hi  = 1'b0;
        shift_b   = 1'b0;
        shift_lo  = 1'b0;
        clr_carry = 1'b0;
        clr_in    = 1'b0;
        ce_in     = 1'b0;
        clr_out   = 1'b0;
        ce_out    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    load    = 1'b1;
                    clr_in  = 1'b1;
                    clr_out = 1'b1;
                    next    = ST_INNER;
                end
            end
            ST_INNER: begin
                shift_a  = 1'b1;
                sel_sum  = 1'b1;
                shift_hi = 1'b1;
                ce_in    = 1'b1;
                if (tc_in)
                    next = ST_OUTER;
            end
            ST_OUTER: begin
                shift_b   = 1'b1;
                shift_hi  = 1'b1;
                shift_lo  = 1'b1;
                clr_carry = 1'b1;
                clr_in    = 1'b1;
                ce_out    = 1'b1;
                next      = tc_out ? ST_IDLE : ST_INNER;
            end
            default: next = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/serial_mult_datapath.sv
module serial_mult_datapath #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         shift_a,
    input  logic         sel_sum,
    input  logic         shift_hi,
    input  logic         shift_b,
    input  logic         shift_lo,
    input  logic         clr_carry,
    input  logic [N-1:0] op_a,
    input  logic [N-1:0] op_b,
    output logic [N-1:0] hi,
    output logic [N-1:0] lo,
    output logic         carry
);
    logic [N-1:0] a_q;
    logic [N-1:0] b_q;
    logic         pp_bit;
    logic         fa_sum;
    logic         fa_cout;
    logic         hi_in;

    // single full adder
    assign pp_bit  = a_q[0] & b_q[0];
    assign fa_sum  = hi[0] ^ pp_bit ^ carry;
    assign fa_cout = (hi[0] & pp_bit) | (hi[0] & carry) | (pp_bit & carry);
    assign hi_in   = sel_sum ? fa_sum : carry;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q   <= '0;
            b_q   <= '0;
            hi    <= '0;
            lo    <= '0;
            carry <= 1'b0;
        end else if (load) begin
            a_q   <= op_a;
            b_q   <= op_b;
            hi    <= '0;
            lo    <= '0;
            carry <= 1'b0;
        end else begin
            if (shift_a)
                a_q <= {a_q[0], a_q[N-1:1]};
            if (shift_b)
                b_q <= {1'b0, b_q[N-1:1]};
            if (shift_hi)
                hi <= {hi_in, hi[N-1:1]};
            if (shift_lo)
                lo <= {hi[0], lo[N-1:1]};
            if (clr_carry)
                carry <= 1'b0;
            else if (sel_sum)
                carry <= fa_cout;
        end
    end
endmodule

// File: rtl/serial_mult.sv
module serial_mult
    import serial_mult_pkg::*;
#(
    parameter  int N  = 8,
    localparam int CW = (N > 1) ? $clog2(N) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [N-1:0] op_a,
    input  logic [N-1:0] op_b,
    output logic         done,
    output logic [N-1:0] prod_hi,
    output logic [N-1:0] prod_lo
);
    mul_state_t    state_q;
    logic          load, shift_a, sel_sum, shift_hi, shift_b, shift_lo, clr_carry;
    logic          clr_in, ce_in, clr_out, ce_out;
    logic          tc_in, tc_out;
    logic [CW-1:0] cnt_in;
    logic [CW-1:0] cnt_out;
    logic          carry_q;

    serial_mult_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .tc_in     (tc_in),
        .tc_out    (tc_out),
        .state     (state_q),
        .done      (done),
        .load      (load),
        .shift_a   (shift_a),
        .sel_sum   (sel_sum),
        .shift_hi  (shift_hi),
        .shift_b   (shift_b),
        .shift_lo  (shift_lo),
        .clr_carry (clr_carry),
        .clr_in    (clr_in),
        .ce_in     (ce_in),
        .clr_out   (clr_out),
        .ce_out    (ce_out)
    );

    serial_mult_counter #(.LIMIT(N)) u_cnt_inner (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_in),
        .ce    (ce_in),
        .count (cnt_in),
        .tc    (tc_in)
    );

    serial_mult_counter #(.LIMIT(N)) u_cnt_outer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_out),
        .ce    (ce_out),
        .count (cnt_out),
        .tc    (tc_out)
    );

    serial_mult_datapath #(.N(N)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .shift_a   (shift_a),
        .sel_sum   (sel_sum),
        .shift_hi  (shift_hi),
        .shift_b   (shift_b),
        .shift_lo  (shift_lo),
        .clr_carry (clr_carry),
        .op_a      (op_a),
        .op_b      (op_b),
        .hi        (prod_hi),
        .lo        (prod_lo),
        .carry     (carry_q)
    );
endmodule

// File: rtl/serial_mult_checker.sv
module serial_mult_checker
    import serial_mult_pkg::*;
#(
    parameter  int N  = 8,
    localparam int CW = (N > 1) ? $clog2(N) : 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          done,
    input mul_state_t    state,
    input logic [CW-1:0] cnt_in,
    input logic [CW-1:0] cnt_out,
    input logic          carry,
    input logic [N-1:0]  prod_hi,
    input logic [N-1:0]  prod_lo
);
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    AST_START_ENTERS_INNER: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start) |=> (state == ST_INNER && cnt_in == '0 && cnt_out == '0 && carry == 1'b0)); // R2

    AST_INNER_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_INNER && cnt_in != LAST) |=> (state == ST_INNER && cnt_in == CW'($past(cnt_in) + 1'b1))); // R3

    AST_INNER_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_INNER && cnt_in == LAST) |=> (state == ST_OUTER)); // R3

    AST_OUTER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OUTER) |=> (carry == 1'b0 && cnt_in == '0)); // R4

    AST_OUTER_LOOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OUTER && cnt_out != LAST) |=> (state == ST_INNER && !done)); // R4

    AST_FINISH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OUTER && cnt_out == LAST) |=> (state == ST_IDLE && done)); // R5

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5

    AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_INNER && cnt_in != LAST) |=> (state != ST_IDLE)); // R7

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !start) |=> ($stable(prod_hi) && $stable(prod_lo))); // R8
endmodule

bind serial_mult serial_mult_checker #(.N(N)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .done    (done),
    .state   (state_q),
    .cnt_in  (cnt_in),
    .cnt_out (cnt_out),
    .carry   (carry_q),
    .prod_hi (prod_hi),
    .prod_lo (prod_lo)
);

// File: tb/serial_mult_bench.sv
`timescale 1ns/1ps
module serial_mult_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       st8, st4;
    logic [7:0] a8, b8;
    logic [3:0] a4, b4;
    logic       done8, done4;
    logic [7:0] hi8, lo8;
    logic [3:0] hi4, lo4;
    int         n_vec = 0;
    int         n_bad = 0;

    always #2.5 clk = ~clk;

    serial_mult #(.N(8)) u_serial_mult (
        .clk(clk), .rst_n(rst_n), .start(st8), .op_a(a8), .op_b(b8),
        .done(done8), .prod_hi(hi8), .prod_lo(lo8)
    );

    serial_mult #(.N(4)) u_serial_mult_n4 (
        .clk(clk), .rst_n(rst_n), .start(st4), .op_a(a4), .op_b(b4),
        .done(done4), .prod_hi(hi4), .prod_lo(lo4)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] product(input int w);
        return (w == 8) ? {hi8, lo8} : {8'h00, hi4, lo4};
    endfunction

    function automatic logic got_done(input int w);
        return (w == 8) ? done8 : done4;
    endfunction

    task automatic drive(input int w, input logic s, input logic [7:0] x, input logic [7:0] y);
        if (w == 8) begin st8 = s; a8 = x; b8 = y; end
        else begin st4 = s; a4 = x[3:0]; b4 = y[3:0]; end
    endtask

    function automatic logic [15:0] ref_mul(input int w, input logic [7:0] x, input logic [7:0] y);
        if (w == 8) return 16'(x) * 16'(y);
        return 16'(x[3:0]) * 16'(y[3:0]);
    endfunction

    task automatic run_mul(input int w, input logic [7:0] x, input logic [7:0] y, input bit poke);
        int            lat;
        logic [15:0]   exp;
        logic [15:0]   held;
        exp = ref_mul(w, x, y);
        @(negedge clk);
        drive(w, 1'b1, x, y);
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
            if (poke) drive(w, (lat == 5) || (lat == 9), ~x, ~y);
            else      drive(w, 1'b0, x, y);
        end while (!got_done(w) && lat < 200);
        drive(w, 1'b0, x, y);
        check(poke ? "R7 latency" : "R5 latency", 16'(lat), 16'(w * (w + 1) + 1));
        check(poke ? "R7 product" : "R2/R3/R4/R6 product", product(w), exp);
        held = product(w);
        @(negedge clk);
        check("R5 done pulse width", {15'd0, got_done(w)}, 16'd0);
        drive(w, 1'b0, ~x, y ^ 8'h5a);
        repeat (3) @(negedge clk);
        check("R8 idle hold", product(w), held);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h00c0ffee));
        rst_n = 1'b0;
        drive(8, 1'b0, 8'h00, 8'h00);
        drive(4, 1'b0, 8'h00, 8'h00);
        repeat (3) @(negedge clk);
        check("R1 reset product n8", product(8), 16'h0000);
        check("R1 reset product n4", product(4), 16'h0000);
        check("R1 reset done", {14'd0, done8, done4}, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", {14'd0, done8, done4}, 16'h0000);

        for (int k = 0; k < 2; k++) begin
            int         w;
            logic [7:0] mx;
            w  = (k == 0) ? 4 : 8;
            mx = (w == 8) ? 8'hff : 8'h0f;
            run_mul(w, 8'h00, 8'h00, 1'b0);
            run_mul(w, 8'h00, mx,    1'b0);
            run_mul(w, mx,    8'h00, 1'b0);
            run_mul(w, 8'h01, mx,    1'b0);
            run_mul(w, mx,    8'h01, 1'b0);
            run_mul(w, 8'h01, 8'h01, 1'b0);
            run_mul(w, mx,    mx,    1'b0);
            run_mul(w, mx,    8'h05, 1'b1);
            for (int r = 0; r < 30; r++) begin
                logic [7:0] x;
                logic [7:0] y;
                x = 8'($urandom) & mx;
                y = 8'($urandom) & mx;
                run_mul(w, x, y, (r % 7) == 3);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule